// File: doc/BRIEF.md
# Graphics Memory Data Port

This block is the processor-side window into the memory of a tile-graphics video controller. The processor selects one of six byte registers with a 3-bit select code, and the block turns those accesses into traffic on three stores. The first is pattern memory, which aliases every 2^PAT_AW bytes. The second is nametable memory: two physical 1 KB pages, mapped according to a mirroring selection. The third is a 32-entry palette. A 14-bit video address register points into this space. It is loaded by two byte writes and steps by 1 or 32 after every data access.

Reads of the data register are pipelined through a one-byte buffer. A read below the palette hands back what an earlier read fetched, then refills the buffer from the current address. Palette reads answer straight away, and they still refill the buffer from the nametable that lies under the palette range. Palette writes keep a raw copy and a render copy. The render copy is 6 bits wide, is read through its own port, and is left alone for the first entry of each group of four.

All register traffic passes through one byte-wide bus latch, and `rd_data` always presents that latch. A register read therefore shows its result one cycle after the read strobe.

Top module: `gfx_data_port`

## Requirements
- R1: Every data access (select 5) steps the video address by 1, or by 32 when control bit 2 is set (last write to select 0). The address wraps within 14 bits, so an access at 0x3FFF is followed by one at 0x0000.
- R2: A data read at an address below 0x3F00 returns the buffer contents. The buffer is then refilled from that address, and back-to-back reads return consecutive bytes.
- R3: A data read at 0x3F00 or above returns palette entry (address & 0x1F) in the next cycle. The buffer is refilled from address & 0x2FFF.
- R4: A palette write stores the byte at index (address & 0x1F). When the index's two low bits are 00, the byte is also stored at index ^ 0x10. Other indices have no mirror.
- R5: The render copy (`rnd_data` at `rnd_idx`) takes the low 6 bits of a palette write only when the index's two low bits are not 00. Otherwise it is left unchanged.
- R6: Addresses 0x2000–0x3EFF select nametable page by `mirror_mode`: 0 uses address bit 11, 1 uses bit 10, 2 always uses page 0, 3 always uses page 1. Addresses 0x3000–0x3EFF alias 0x2000–0x2EFF.
- R7: A status read (select 1) loads `status_in` into latch bits 7:5 and keeps latch bits 4:0.
- R8: Select 2 writes the sprite address. A sprite data write (select 3) stores the byte and steps the sprite address. A sprite data read returns the byte at the sprite address and loads it into the latch.
- R9: Any register write loads the written byte into the latch. Every register read returns the latch on `rd_data` one cycle later, and reads of select 0, 2 and 4 leave the latch unchanged.
- R10: Data writes below 0x2000 are ignored unless `pat_is_ram` is 1.
- R11: Reset clears the video address, the read buffer, the latch and the palette copies to zero.
- R12: Select 4 writes load address bits 13:8 (from data bits 5:0) and then bits 7:0, alternately. A status read makes the next select-4 write a high-byte write again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select code |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe (wins over rd_en) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Bus latch contents |
| mirror_mode | input | 2 | Nametable page mapping |
| pat_is_ram | input | 1 | Pattern memory accepts writes |
| status_in | input | 3 | Status flags shown on a status read |
| rnd_idx | input | 5 | Render palette index |
| rnd_data | output | 6 | Render palette entry |

## Verification
The hardest state to reach is a palette read whose buffer refill lands on a nametable byte. That byte only becomes visible on a later non-palette read, after the address has been reloaded. The stimulus first plants a known byte at 0x2F10 and reads palette address 0x3F10. It then moves the address elsewhere and reads once, expecting the planted byte. Back-to-back data reads are also issued so that the one-cycle memory latency has to be bridged while a refill is still in flight.

// File: rtl/gfx_port_pkg.sv
package gfx_port_pkg;
    localparam int DW          = 8;
    localparam int VA_W        = 14;
    localparam int STAT_W      = 3;
    localparam int CTRL_INC_BIT = 2;
    localparam int NT_PAGE_AW  = 10;
    localparam int NT_AW       = NT_PAGE_AW + 1;

    localparam logic [2:0] SEL_CTRL     = 3'd0;
    localparam logic [2:0] SEL_STAT     = 3'd1;
    localparam logic [2:0] SEL_SPR_ADDR = 3'd2;
    localparam logic [2:0] SEL_SPR_DATA = 3'd3;
    localparam logic [2:0] SEL_VADDR    = 3'd4;
    localparam logic [2:0] SEL_VDATA    = 3'd5;

    typedef enum logic [1:0] {
        MIR_BY_BIT11 = 2'd0,
        MIR_BY_BIT10 = 2'd1,
        MIR_ONE_LO   = 2'd2,
        MIR_ONE_HI   = 2'd3
    } mirror_t;
endpackage

// File: rtl/gfx_sync_ram.sv
module gfx_sync_ram #(
    parameter int AW      = 10,
    parameter int DW      = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    generate
        if (REG_OUT) begin : g_sync_rd
            logic [DW-1:0] rdata_q;
            always_ff @(posedge clk) begin
                rdata_q <= mem_q[raddr];
            end
            assign rdata = rdata_q;
        end else begin : g_comb_rd
            assign rdata = mem_q[raddr];
        end
    endgenerate
endmodule

// File: rtl/gfx_nt_map.sv
module gfx_nt_map
    import gfx_port_pkg::*;
(
    input  logic [11:0]      vaddr,
    input  logic [1:0]       mode,
    output logic [NT_AW-1:0] phys
);
    logic page;

    always_comb begin
        case (mirror_t'(mode))
            MIR_BY_BIT11: page = vaddr[11];
            MIR_BY_BIT10: page = vaddr[10];
            MIR_ONE_LO:   page = 1'b0;
            default:      page = 1'b1;
        endcase
        phys = {page, vaddr[NT_PAGE_AW-1:0]};
    end
endmodule

// File: rtl/gfx_palette.sv
module gfx_palette #(
    parameter int PAL_N = 32,
    parameter int DW    = 8,
    parameter int RW    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(PAL_N)-1:0] idx,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            cpu_rdata,
    input  logic [$clog2(PAL_N)-1:0] rnd_idx,
    output logic [RW-1:0]            rnd_data
);
    localparam int IDX_W = $clog2(PAL_N);
    localparam logic [IDX_W-1:0] MIRROR_FLIP = IDX_W'(1) << (IDX_W - 1);

    typedef struct packed {
        logic [PAL_N-1:0][DW-1:0] raw;
        logic [PAL_N-1:0][RW-1:0] rnd;
    } pal_state_t;

    pal_state_t pal_d, pal_q;

    always_comb begin
        pal_d = pal_q;
        if (we) begin
            pal_d.raw[idx] = wdata;
            if (idx[1:0] == 2'b00) begin
                pal_d.raw[idx ^ MIRROR_FLIP] = wdata;
            end else begin
                pal_d.rnd[idx] = wdata[RW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_q <= '0;
        end else begin
            pal_q <= pal_d;
        end
    end

    assign cpu_rdata = pal_q.raw[idx];
    assign rnd_data  = pal_q.rnd[rnd_idx];

    AST_PAL_GROUP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx[1:0] == 2'b00) |=> pal_q.raw[$past(idx) ^ MIRROR_FLIP] == $past(wdata)); // R4

    AST_RND_GROUP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx[1:0] == 2'b00) |=> pal_q.rnd[$past(idx)] == $past(pal_q.rnd[idx])); // R5
endmodule

// File: rtl/gfx_data_port.sv
module gfx_data_port
    import gfx_port_pkg::*;
#(
    parameter int PAT_AW = 10,
    parameter int SPR_AW = 8,
    parameter int PAL_N  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               reg_sel,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            rd_data,
    input  logic [1:0]               mirror_mode,
    input  logic                     pat_is_ram,
    input  logic [STAT_W-1:0]        status_in,
    input  logic [$clog2(PAL_N)-1:0] rnd_idx,
    output logic [5:0]               rnd_data
);
    localparam int PAL_IW = $clog2(PAL_N);
    localparam logic [VA_W-1:0] NT_UNDER_MASK = 14'h2FFF;
    localparam logic [5:0]      PAL_PAGE      = 6'h3F;

    typedef struct packed {
        logic [VA_W-1:0]   addr;
        logic [DW-1:0]     rbuf;
        logic [DW-1:0]     bus;
        logic              inc32;
        logic              toggle;
        logic              pend;
        logic              pend_nt;
        logic [SPR_AW-1:0] spr_addr;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [VA_W-1:0]  step;
    logic             is_pal;
    logic             is_nt;
    logic [VA_W-1:0]  fetch_addr;
    logic [NT_AW-1:0] nt_phys;
    logic [DW-1:0]    nt_rdata;
    logic [DW-1:0]    pat_rdata;
    logic [DW-1:0]    pal_rdata;
    logic [DW-1:0]    spr_rdata;
    logic [DW-1:0]    buf_eff;
    logic             vdata_wr;
    logic             nt_we;
    logic             pat_we;
    logic             pal_we;
    logic             spr_we;

    assign step       = st_q.inc32 ? VA_W'(32) : VA_W'(1);
    assign is_pal     = (st_q.addr[VA_W-1:8] == PAL_PAGE);
    assign is_nt      = st_q.addr[VA_W-1];
    assign fetch_addr = is_pal ? (st_q.addr & NT_UNDER_MASK) : st_q.addr;
    assign buf_eff    = st_q.pend ? (st_q.pend_nt ? nt_rdata : pat_rdata) : st_q.rbuf;

    assign vdata_wr = wr_en && (reg_sel == SEL_VDATA);
    assign pal_we   = vdata_wr && is_pal;
    assign nt_we    = vdata_wr && is_nt && !is_pal;
    assign pat_we   = vdata_wr && !is_nt && pat_is_ram;
    assign spr_we   = wr_en && (reg_sel == SEL_SPR_DATA);

    gfx_nt_map i_nt_map (
        .vaddr (fetch_addr[11:0]),
        .mode  (mirror_mode),
        .phys  (nt_phys)
    );

    gfx_sync_ram #(.AW(NT_AW), .DW(DW), .REG_OUT(1'b1)) i_nt_ram (
        .clk   (clk),
        .we    (nt_we),
        .waddr (nt_phys),
        .wdata (wr_data),
        .raddr (nt_phys),
        .rdata (nt_rdata)
    );

    gfx_sync_ram #(.AW(PAT_AW), .DW(DW), .REG_OUT(1'b1)) i_pat_ram (
        .clk   (clk),
        .we    (pat_we),
        .waddr (st_q.addr[PAT_AW-1:0]),
        .wdata (wr_data),
        .raddr (st_q.addr[PAT_AW-1:0]),
        .rdata (pat_rdata)
    );

    gfx_sync_ram #(.AW(SPR_AW), .DW(DW), .REG_OUT(1'b0)) i_spr_ram (
        .clk   (clk),
        .we    (spr_we),
        .waddr (st_q.spr_addr),
        .wdata (wr_data),
        .raddr (st_q.spr_addr),
        .rdata (spr_rdata)
    );

    gfx_palette #(.PAL_N(PAL_N), .DW(DW), .RW(6)) i_palette (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (pal_we),
        .idx       (st_q.addr[PAL_IW-1:0]),
        .wdata     (wr_data),
        .cpu_rdata (pal_rdata),
        .rnd_idx   (rnd_idx),
        .rnd_data  (rnd_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        st_d.rbuf = buf_eff;
        if (wr_en) begin
            st_d.bus = wr_data;
            case (reg_sel)
                SEL_CTRL:     st_d.inc32 = wr_data[CTRL_INC_BIT];
                SEL_SPR_ADDR: st_d.spr_addr = wr_data[SPR_AW-1:0];
                SEL_SPR_DATA: st_d.spr_addr = st_q.spr_addr + 1'b1;
                SEL_VADDR: begin
                    if (!st_q.toggle) begin
                        st_d.addr = {wr_data[VA_W-9:0], st_q.addr[7:0]};
                    end else begin
                        st_d.addr = {st_q.addr[VA_W-1:8], wr_data};
                    end
                    st_d.toggle = !st_q.toggle;
                end
                SEL_VDATA:    st_d.addr = st_q.addr + step;
                default: ;
            endcase
        end else if (rd_en) begin
            case (reg_sel)
                SEL_STAT: begin
                    st_d.bus    = {status_in, st_q.bus[DW-STAT_W-1:0]};
                    st_d.toggle = 1'b0;
                end
                SEL_SPR_DATA: st_d.bus = spr_rdata;
                SEL_VDATA: begin
                    st_d.bus     = is_pal ? pal_rdata : buf_eff;
                    st_d.pend    = 1'b1;
                    st_d.pend_nt = fetch_addr[VA_W-1];
                    st_d.addr    = st_q.addr + step;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.bus;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && reg_sel == SEL_VDATA)
            |=> st_q.addr == VA_W'($past(st_q.addr) + $past(step))); // R1

    AST_WRITE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data)); // R9

    AST_STATUS_OPEN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && reg_sel == SEL_STAT)
            |=> (rd_data[DW-STAT_W-1:0] == $past(rd_data[DW-STAT_W-1:0]))
                && (rd_data[DW-1:DW-STAT_W] == $past(status_in))); // R7

    AST_PAL_NO_REFILL_FROM_PAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && reg_sel == SEL_VDATA && is_pal) |=> st_q.pend_nt); // R3
endmodule

// File: tb/test_gfx_data_port.sv
`timescale 1ns/1ps
module test_gfx_data_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_sel = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] mirror_mode = 2'd1;
    logic       pat_is_ram = 1'b1;
    logic [2:0] status_in = 3'b101;
    logic [4:0] rnd_idx = '0;
    logic [5:0] rnd_data;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
        int         due;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gfx_data_port i_gfx_data_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_sel     (reg_sel),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .mirror_mode (mirror_mode),
        .pat_is_ram  (pat_is_ram),
        .status_in   (status_in),
        .rnd_idx     (rnd_idx),
        .rnd_data    (rnd_data)
    );

    task automatic compare(input logic [7:0] act, input logic [7:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected bytes once their cycle has come
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_item_t it;
            it = sb_q.pop_front();
            compare(rd_data, it.exp, it.tag);
        end
    end

    task automatic op(input bit rd, input bit wr, input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        rd_en = rd; wr_en = wr; reg_sel = sel; wr_data = d;
    endtask

    task automatic idle();
        op(1'b0, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        op(1'b0, 1'b1, sel, d);
    endtask

    task automatic wr_chk(input logic [2:0] sel, input logic [7:0] d, input string tag);
        exp_item_t it;
        op(1'b0, 1'b1, sel, d);
        it.exp = d; it.tag = tag; it.due = cyc + 1;
        sb_q.push_back(it);
    endtask

    task automatic rd_chk(input logic [2:0] sel, input logic [7:0] e, input string tag);
        exp_item_t it;
        op(1'b1, 1'b0, sel, 8'h00);
        it.exp = e; it.tag = tag; it.due = cyc + 1;
        sb_q.push_back(it);
    endtask

    task automatic rd_skip(input logic [2:0] sel);
        op(1'b1, 1'b0, sel, 8'h00);
    endtask

    task automatic set_addr(input logic [15:0] a);
        wr(3'd4, a[15:8]);
        wr(3'd4, a[7:0]);
    endtask

    task automatic rnd_chk(input logic [4:0] i, input logic [5:0] e, input string tag);
        idle();
        rnd_idx = i;
        #1;
        compare({2'b00, rnd_data}, {2'b00, e}, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare(rd_data, 8'h00, "R11 latch at reset");

        set_addr(16'h2005);
        wr_chk(3'd5, 8'hA1, "R9 write loads latch");
        wr(3'd5, 8'hA2);
        set_addr(16'h2005);
        rd_chk(3'd5, 8'h00, "R11 buffer cleared by reset");
        rd_chk(3'd5, 8'hA1, "R2 delayed read");
        rd_chk(3'd5, 8'hA2, "R2 back-to-back read");

        // step of 32 on write and read
        wr(3'd0, 8'h04);
        set_addr(16'h2000);
        wr(3'd5, 8'h10);
        wr(3'd5, 8'h20);
        set_addr(16'h2000);
        rd_skip(3'd5);
        rd_chk(3'd5, 8'h10, "R1 step 32 first");
        rd_chk(3'd5, 8'h20, "R1 step 32 second");
        wr(3'd0, 8'h00);

        // nametable mirroring
        set_addr(16'h2C10);
        wr(3'd5, 8'h5C);
        set_addr(16'h2410);
        rd_skip(3'd5);
        rd_chk(3'd5, 8'h5C, "R6 mode 1 by bit 10");
        set_addr(16'h3410);
        rd_skip(3'd5);
        rd_chk(3'd5, 8'h5C, "R6 0x3000 alias");
        idle(); mirror_mode = 2'd0;
        set_addr(16'h2810);
        rd_skip(3'd5);
        rd_chk(3'd5, 8'h5C, "R6 mode 0 by bit 11");
        idle(); mirror_mode = 2'd2;
        set_addr(16'h2C05);
        rd_skip(3'd5);
        rd_chk(3'd5, 8'hA1, "R6 mode 2 page 0");
        idle(); mirror_mode = 2'd3;
        set_addr(16'h2010);
        rd_skip(3'd5);
        rd_chk(3'd5, 8'h5C, "R6 mode 3 page 1");
        idle(); mirror_mode = 2'd1;

        // palette
        set_addr(16'h2F10);
        wr(3'd5, 8'h9D);
        set_addr(16'h3F00);
        wr(3'd5, 8'h15);
        wr(3'd5, 8'hC7);
        set_addr(16'h3F10);
        rd_chk(3'd5, 8'h15, "R4 group-zero mirror, R3 immediate");
        set_addr(16'h2005);
        rd_chk(3'd5, 8'h9D, "R3 buffer from nametable under palette");
        rnd_chk(5'd1, 6'h07, "R5 render copy low 6 bits");
        rnd_chk(5'd0, 6'h00, "R5 group zero not in render copy");
        rnd_chk(5'h10, 6'h00, "R5 mirrored group zero not in render copy");
        set_addr(16'h3F14);
        wr(3'd5, 8'h2B);
        set_addr(16'h3F04);
        rd_chk(3'd5, 8'h2B, "R4 mirror 0x14 to 0x04");
        set_addr(16'h3F11);
        rd_chk(3'd5, 8'h00, "R4 no mirror for index 0x01");

        // wrap from 0x3FFF to 0x0000
        set_addr(16'h3FFF);
        wr(3'd5, 8'h2A);
        wr(3'd5, 8'h77);
        set_addr(16'h0000);
        rd_skip(3'd5);
        rd_chk(3'd5, 8'h77, "R1 wrap to zero");
        set_addr(16'h3F1F);
        rd_chk(3'd5, 8'h2A, "R3 palette entry 31");

        // pattern write protection
        set_addr(16'h0040);
        wr(3'd5, 8'h33);
        idle(); pat_is_ram = 1'b0;
        set_addr(16'h0040);
        wr(3'd5, 8'h55);
        set_addr(16'h0040);
        rd_skip(3'd5);
        rd_chk(3'd5, 8'h33, "R10 pattern write ignored");

        // status open bus
        wr(3'd0, 8'h1B);
        rd_chk(3'd1, 8'hBB, "R7 status upper bits, low bits kept");

        // sprite path
        wr(3'd2, 8'h10);
        wr(3'd3, 8'h6E);
        wr(3'd3, 8'h6F);
        wr(3'd2, 8'h10);
        rd_chk(3'd3, 8'h6E, "R8 sprite read");
        rd_chk(3'd0, 8'h6E, "R9 plain read returns latch");
        wr(3'd2, 8'h11);
        rd_chk(3'd3, 8'h6F, "R8 sprite address stepped on write");

        // address write sequence reset by status read
        wr(3'd4, 8'h21);
        rd_skip(3'd1);
        wr(3'd4, 8'h20);
        wr(3'd4, 8'h05);
        rd_skip(3'd5);
        rd_chk(3'd5, 8'hA1, "R12 status read restarts address writes");

        idle();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule